// File: doc/BRIEF.md
# Dispatch Group Former

This unit sits between instruction decode and the issue queues. It receives one decoded instruction per cycle over a ready/valid stream. Each instruction carries a tag and a three-bit class code. The unit packs these instructions into dispatch groups of six slots. Slots 0 to 3 take non-branch work and slots 4 and 5 take branches. A group is not closed by a simple count. It closes when the next instruction has no legal place in it, when a second branch joins it, or when the stream goes quiet for a programmable number of cycles.

A closed group moves into an output register. That register is offered downstream with one valid bit per slot and the tag of the instruction that owns each slot. While the output register waits on back-pressure, the unit keeps building the next group in a separate build register. Upstream is stalled only when an instruction would need the output register while that register is still occupied.

Top module: `dgf_group_former`

## Requirements
- R1: While reset is asserted and directly after it, `grp_valid_o` is 0 and `in_ready_o` is 1.
- R2: Class 0 (plain) takes the lowest free non-branch slot, in arrival order. A plain instruction that finds slots 0 to 3 used or skipped closes the current group and opens the next one. Bit i of `grp_slot_vld_o` is slot i, and the tag of slot i is `grp_tag_o[i*TAG_W +: TAG_W]`.
- R3: Class 5 (branch) takes slot 4 if it is the first branch and slot 5 if it is the second. A first branch leaves the group open, so later non-branch instructions still join it.
- R4: A second branch closes its group at once. The group is offered from the cycle after that branch is accepted, and slot 5 is never valid without slot 4.
- R5: Class 1 (pair) fills slots 0 and 1, and class 2 (quad) fills slots 0 to 3. Each one needs a group with no instruction in it, branches included. Otherwise it closes the current group and starts the next one.
- R6: Class 3 (write-condition) may only use slot 3. It fits while slot 3 is free, and it skips slots 1 and 2. A non-branch instruction that follows it closes the group.
- R7: Class 4 (read-condition) may only use slot 0 and needs an empty group. Otherwise it closes the current group.
- R8: Codes 6 and 7 are placed in the same way as class 0.
- R9: If a partial group receives no valid input, it is closed and offered after `tmo_limit_i`+1 clock edges counted from its last acceptance. This includes the case where `tmo_limit_i` is 0, which gives one edge.
- R10: While `grp_ready_i` is low, an offered group and its tags stay unchanged. An instruction that fits the build register without closing it is still accepted. `in_ready_o` falls only for an instruction that needs the occupied output register. No group is lost or repeated.
- R11: An offered group never has all slot-valid bits at 0. A multi-slot instruction repeats its tag in every slot it fills. The tags of slots whose valid bit is 0 carry no meaning.
- R12: A timeout that expires while the output register is held waits for it to drain. The pending group is then offered in the cycle straight after the held group is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Instruction present |
| in_ready_o | output | 1 | Instruction accepted this cycle when valid |
| in_cls_i | input | 3 | Placement class code |
| in_tag_i | input | TAG_W | Instruction tag |
| tmo_limit_i | input | TMO_W | Idle cycles allowed before a partial group is closed |
| grp_valid_o | output | 1 | Group offered downstream |
| grp_ready_i | input | 1 | Downstream accepts the group (low = stall) |
| grp_slot_vld_o | output | NB_SLOTS+BR_SLOTS | Per-slot valid bits |
| grp_tag_o | output | (NB_SLOTS+BR_SLOTS)*TAG_W | Per-slot tags, slot 0 in the low bits |

## Verification
Two events can land on the same clock edge. One is a group closing, because an instruction does not fit or the idle timer expires. The other is downstream accepting the group already held in the output register. The bench sets up both overlaps with `grp_ready_i` held low: a pair arrives behind a plain instruction while a later pair waits, and, separately, the idle timer expires behind a stalled group. It then releases the stall. The checks confirm that the waiting group is offered in the very next cycle, that every group appears exactly once with its own mask and tags, and that `in_ready_o` fell only while the waiting instruction needed the output register.

// File: rtl/dgf_pkg.sv
package dgf_pkg;
  localparam int CLS_W = 3;
  localparam logic [CLS_W-1:0] CLS_PLAIN   = 3'd0;
  localparam logic [CLS_W-1:0] CLS_PAIR    = 3'd1;
  localparam logic [CLS_W-1:0] CLS_QUAD    = 3'd2;
  localparam logic [CLS_W-1:0] CLS_CR_WR   = 3'd3;
  localparam logic [CLS_W-1:0] CLS_CR_RD   = 3'd4;
  localparam logic [CLS_W-1:0] CLS_BRANCH  = 3'd5;
endpackage

// File: rtl/dgf_slot_fit.sv
module dgf_slot_fit
  import dgf_pkg::*;
#(
  parameter int NB_SLOTS = 4,
  parameter int BR_SLOTS = 2,
  localparam int SLOTS = NB_SLOTS + BR_SLOTS,
  localparam int PW = $clog2(NB_SLOTS + 1),
  localparam int BW = $clog2(BR_SLOTS + 1)
) (
  input  logic [CLS_W-1:0] cls_i,
  input  logic [PW-1:0]    ptr_i,
  input  logic [BW-1:0]    brc_i,
  output logic [SLOTS-1:0] mask_o,
  output logic [PW-1:0]    ptr_o,
  output logic [BW-1:0]    brc_o
);
  logic empty;
  assign empty = (ptr_i == '0) && (brc_i == '0);

  always_comb begin
    mask_o = '0;
    ptr_o  = ptr_i;
    brc_o  = brc_i;
    unique case (cls_i)
      CLS_PAIR: if (empty) begin
        mask_o[1:0] = 2'b11;
        ptr_o       = PW'(2);
      end
      CLS_QUAD: if (empty) begin
        mask_o[NB_SLOTS-1:0] = '1;
        ptr_o                = PW'(NB_SLOTS);
      end
      CLS_CR_RD: if (empty) begin
        mask_o[0] = 1'b1;
        ptr_o     = PW'(1);
      end
      CLS_CR_WR: if (ptr_i < PW'(NB_SLOTS)) begin
        mask_o[NB_SLOTS-1] = 1'b1;
        ptr_o              = PW'(NB_SLOTS);
      end
      CLS_BRANCH: if (brc_i < BW'(BR_SLOTS)) begin
        mask_o[NB_SLOTS + int'(brc_i)] = 1'b1;
        brc_o                          = brc_i + BW'(1);
      end
      default: if (ptr_i < PW'(NB_SLOTS)) begin
        mask_o[ptr_i] = 1'b1;
        ptr_o         = ptr_i + PW'(1);
      end
    endcase
  end
endmodule

// File: rtl/dgf_idle_timer.sv
module dgf_idle_timer #(
  parameter int TMO_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             busy_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             fire_o
);
  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!active_i || busy_i) cnt_q <= '0;
    else if (cnt_q != limit_i)   cnt_q <= cnt_q + TMO_W'(1);
  end

  assign fire_o = active_i && !busy_i && (cnt_q == limit_i);
endmodule

// File: rtl/dgf_group_former.sv
module dgf_group_former
  import dgf_pkg::*;
#(
  parameter int TAG_W    = 8,
  parameter int NB_SLOTS = 4,
  parameter int BR_SLOTS = 2,
  parameter int TMO_W    = 8,
  localparam int SLOTS = NB_SLOTS + BR_SLOTS,
  localparam int PW = $clog2(NB_SLOTS + 1),
  localparam int BW = $clog2(BR_SLOTS + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   in_valid_i,
  output logic                   in_ready_o,
  input  logic [CLS_W-1:0]       in_cls_i,
  input  logic [TAG_W-1:0]       in_tag_i,
  input  logic [TMO_W-1:0]       tmo_limit_i,
  output logic                   grp_valid_o,
  input  logic                   grp_ready_i,
  output logic [SLOTS-1:0]       grp_slot_vld_o,
  output logic [SLOTS*TAG_W-1:0] grp_tag_o
);
  logic [SLOTS-1:0]             bld_vld_q, out_mask_q, mask_c, mask_n;
  logic [SLOTS-1:0][TAG_W-1:0]  bld_tag_q, out_tag_q, cur_tag, new_tag;
  logic [PW-1:0]                bld_ptr_q, ptr_c, ptr_n;
  logic [BW-1:0]                bld_brc_q, brc_c, brc_n;
  logic                         out_vld_q;
  logic                         bld_empty, fit_c, close_c, can_move, acc, tmo_fire;

  // placement into the open group, and into a fresh one when it does not fit
  dgf_slot_fit #(.NB_SLOTS(NB_SLOTS), .BR_SLOTS(BR_SLOTS)) u_fit_cur (
    .cls_i(in_cls_i), .ptr_i(bld_ptr_q), .brc_i(bld_brc_q),
    .mask_o(mask_c), .ptr_o(ptr_c), .brc_o(brc_c)
  );
  dgf_slot_fit #(.NB_SLOTS(NB_SLOTS), .BR_SLOTS(BR_SLOTS)) u_fit_new (
    .cls_i(in_cls_i), .ptr_i('0), .brc_i('0),
    .mask_o(mask_n), .ptr_o(ptr_n), .brc_o(brc_n)
  );

  dgf_idle_timer #(.TMO_W(TMO_W)) u_idle (
    .clk_i(clk_i), .rst_ni(rst_ni), .active_i(!bld_empty),
    .busy_i(in_valid_i), .limit_i(tmo_limit_i), .fire_o(tmo_fire)
  );

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign cur_tag[g] = mask_c[g] ? in_tag_i : bld_tag_q[g];
    assign new_tag[g] = mask_n[g] ? in_tag_i : '0;
  end

  assign bld_empty  = (bld_ptr_q == '0) && (bld_brc_q == '0);
  assign fit_c      = |mask_c;
  assign close_c    = (in_cls_i == CLS_BRANCH) && (bld_brc_q == BW'(BR_SLOTS - 1));
  assign can_move   = !out_vld_q || grp_ready_i;
  assign in_ready_o = (fit_c && !close_c) || can_move;
  assign acc        = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bld_vld_q  <= '0;
      bld_tag_q  <= '0;
      bld_ptr_q  <= '0;
      bld_brc_q  <= '0;
      out_vld_q  <= 1'b0;
      out_mask_q <= '0;
      out_tag_q  <= '0;
    end else begin
      if (out_vld_q && grp_ready_i) out_vld_q <= 1'b0;
      if (acc) begin
        if (fit_c && !close_c) begin
          bld_vld_q <= bld_vld_q | mask_c;
          bld_tag_q <= cur_tag;
          bld_ptr_q <= ptr_c;
          bld_brc_q <= brc_c;
        end else if (fit_c) begin
          // closing branch: group leaves together with it
          out_vld_q  <= 1'b1;
          out_mask_q <= bld_vld_q | mask_c;
          out_tag_q  <= cur_tag;
          bld_vld_q  <= '0;
          bld_ptr_q  <= '0;
          bld_brc_q  <= '0;
        end else begin
          // no room: ship open group, instruction opens the next one
          out_vld_q  <= 1'b1;
          out_mask_q <= bld_vld_q;
          out_tag_q  <= bld_tag_q;
          bld_vld_q  <= mask_n;
          bld_tag_q  <= new_tag;
          bld_ptr_q  <= ptr_n;
          bld_brc_q  <= brc_n;
        end
      end else if (tmo_fire && can_move) begin
        out_vld_q  <= 1'b1;
        out_mask_q <= bld_vld_q;
        out_tag_q  <= bld_tag_q;
        bld_vld_q  <= '0;
        bld_ptr_q  <= '0;
        bld_brc_q  <= '0;
      end
    end
  end

  assign grp_valid_o    = out_vld_q;
  assign grp_slot_vld_o = out_mask_q;
  assign grp_tag_o      = out_tag_q;
endmodule

// File: rtl/dgf_group_former_chk.sv
module dgf_group_former_chk #(
  parameter int TAG_W = 8,
  parameter int SLOTS = 6
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   in_valid_i,
  input logic                   in_ready_o,
  input logic                   grp_valid_o,
  input logic                   grp_ready_i,
  input logic [SLOTS-1:0]       grp_slot_vld_o,
  input logic [SLOTS*TAG_W-1:0] grp_tag_o
);
  assert_hold_on_stall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_valid_o && !grp_ready_i |=> grp_valid_o && $stable(grp_slot_vld_o) && $stable(grp_tag_o));

  assert_block_only_on_stall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && !in_ready_o |-> grp_valid_o && !grp_ready_i);

  assert_no_empty_group_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_valid_o |-> (grp_slot_vld_o != '0));

  assert_branch_order_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_valid_o && grp_slot_vld_o[SLOTS-1] |-> grp_slot_vld_o[SLOTS-2]);
endmodule

bind dgf_group_former dgf_group_former_chk #(
  .TAG_W(TAG_W), .SLOTS(NB_SLOTS + BR_SLOTS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
  .grp_valid_o(grp_valid_o), .grp_ready_i(grp_ready_i),
  .grp_slot_vld_o(grp_slot_vld_o), .grp_tag_o(grp_tag_o)
);

// File: tb/dgf_group_former_tb.sv
module dgf_group_former_tb;
  localparam int CLK_P = 10;
  localparam int TAG_W = 8;
  localparam int SLOTS = 6;
  localparam int NVEC  = 13;

  localparam logic [2:0] C_S = 3'd0, C_P = 3'd1, C_Q = 3'd2, C_T = 3'd3,
                         C_F = 3'd4, C_B = 3'd5, C_X = 3'd7;

  typedef struct packed {
    logic [7:0]            req;
    logic [2:0]            n;
    logic [4:0][2:0]       cls;   // index 0 is sent first
    logic [SLOTS-1:0]      mask;
    logic [SLOTS-1:0][7:0] tags;
  } vec_t;

  localparam vec_t VEC_TAB [NVEC] = '{
    // R2: four plain fill slots 0..3
    '{req:2,  n:4, cls:{C_S,C_S,C_S,C_S,C_S}, mask:6'h0F, tags:{8'd0,8'd0,8'd4,8'd3,8'd2,8'd1}},
    // R3: first branch keeps group open
    '{req:3,  n:3, cls:{C_S,C_S,C_B,C_S,C_B}, mask:6'h31, tags:{8'd3,8'd1,8'd0,8'd0,8'd0,8'd2}},
    // R5: pair behind plain closes group
    '{req:5,  n:2, cls:{C_S,C_S,C_S,C_P,C_S}, mask:6'h01, tags:{8'd0,8'd0,8'd0,8'd0,8'd0,8'd1}},
    // R11: pair repeats tag in slots 0 and 1
    '{req:11, n:3, cls:{C_S,C_S,C_S,C_S,C_P}, mask:6'h0F, tags:{8'd0,8'd0,8'd3,8'd2,8'd1,8'd1}},
    // R6: write-condition skips to slot 3
    '{req:6,  n:2, cls:{C_S,C_S,C_S,C_T,C_S}, mask:6'h09, tags:{8'd0,8'd0,8'd2,8'd0,8'd0,8'd1}},
    // R6: plain after write-condition closes
    '{req:6,  n:2, cls:{C_S,C_S,C_S,C_S,C_T}, mask:6'h08, tags:{8'd0,8'd0,8'd1,8'd0,8'd0,8'd0}},
    // R4: quad plus two branches, full group
    '{req:4,  n:3, cls:{C_S,C_S,C_B,C_B,C_Q}, mask:6'h3F, tags:{8'd3,8'd2,8'd1,8'd1,8'd1,8'd1}},
    // R7: read-condition behind a branch closes
    '{req:7,  n:2, cls:{C_S,C_S,C_S,C_F,C_B}, mask:6'h10, tags:{8'd0,8'd1,8'd0,8'd0,8'd0,8'd0}},
    // R2: fifth plain opens the next group
    '{req:2,  n:5, cls:{C_S,C_S,C_S,C_S,C_S}, mask:6'h0F, tags:{8'd0,8'd0,8'd4,8'd3,8'd2,8'd1}},
    // R4: second branch closes immediately
    '{req:4,  n:3, cls:{C_S,C_S,C_S,C_B,C_B}, mask:6'h30, tags:{8'd2,8'd1,8'd0,8'd0,8'd0,8'd0}},
    // R8: code 7 placed as plain
    '{req:8,  n:2, cls:{C_S,C_S,C_S,C_S,C_X}, mask:6'h03, tags:{8'd0,8'd0,8'd0,8'd0,8'd2,8'd1}},
    // R7: read-condition in slot 0 of an empty group
    '{req:7,  n:4, cls:{C_S,C_S,C_S,C_S,C_F}, mask:6'h0F, tags:{8'd0,8'd0,8'd4,8'd3,8'd2,8'd1}},
    // R5: quad behind plain closes group
    '{req:5,  n:2, cls:{C_S,C_S,C_S,C_Q,C_S}, mask:6'h01, tags:{8'd0,8'd0,8'd0,8'd0,8'd0,8'd1}}
  };

  logic                   clk_i = 1'b0;
  logic                   rst_ni = 1'b0;
  logic                   in_valid_i = 1'b0;
  logic                   in_ready_o;
  logic [2:0]             in_cls_i = '0;
  logic [TAG_W-1:0]       in_tag_i = '0;
  logic [7:0]             tmo_limit_i = 8'd3;
  logic                   grp_valid_o;
  logic                   grp_ready_i = 1'b1;
  logic [SLOTS-1:0]       grp_slot_vld_o;
  logic [SLOTS*TAG_W-1:0] grp_tag_o;

  int checks = 0;
  int fails  = 0;
  int log_n  = 0;
  bit done   = 1'b0;
  logic [SLOTS-1:0]       log_mask [64];
  logic [SLOTS*TAG_W-1:0] log_tag  [64];

  always #(CLK_P/2) clk_i = ~clk_i;

  dgf_group_former u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .in_cls_i(in_cls_i), .in_tag_i(in_tag_i), .tmo_limit_i(tmo_limit_i),
    .grp_valid_o(grp_valid_o), .grp_ready_i(grp_ready_i),
    .grp_slot_vld_o(grp_slot_vld_o), .grp_tag_o(grp_tag_o)
  );

  // record each handshake; sampled between negedge and the next posedge
  initial forever begin
    @(negedge clk_i);
    #(CLK_P/4);
    if (rst_ni && grp_valid_o && grp_ready_i && log_n < 64) begin
      log_mask[log_n] = grp_slot_vld_o;
      log_tag[log_n]  = grp_tag_o;
      log_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] c, input logic [7:0] t);
    @(negedge clk_i);
    in_valid_i = 1'b1;
    in_cls_i   = c;
    in_tag_i   = t;
    forever begin
      #(CLK_P/4);
      if (in_ready_o) begin
        @(posedge clk_i);
        break;
      end
      @(negedge clk_i);
    end
  endtask

  task automatic go_idle(input int cyc);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    repeat (cyc) @(negedge clk_i);
  endtask

  function automatic logic [7:0] tag_of(input logic [SLOTS*TAG_W-1:0] v, input int s);
    return v[s*TAG_W +: TAG_W];
  endfunction

  initial begin
    repeat (3) @(negedge clk_i);
    chk(grp_valid_o == 1'b0 && in_ready_o == 1'b1, "R1 in reset", {grp_valid_o, in_ready_o}, 2'b01);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(grp_valid_o == 1'b0 && in_ready_o == 1'b1, "R1 after reset", {grp_valid_o, in_ready_o}, 2'b01);

    // table walk: ready high, timeout 3, first group of each sequence compared
    for (int i = 0; i < NVEC; i++) begin
      int  base;
      bit  ok;
      vec_t v;
      v    = VEC_TAB[i];
      base = log_n;
      for (int k = 0; k < int'(v.n); k++) send(v.cls[k], 8'(k + 1));
      go_idle(20);
      ok = (log_n > base) && (log_mask[base] == v.mask);
      for (int s = 0; s < SLOTS; s++)
        if (ok && v.mask[s] && tag_of(log_tag[base], s) != v.tags[s]) ok = 1'b0;
      chk(ok, $sformatf("R%0d vec%0d", v.req, i), {log_mask[base], log_tag[base]}, {v.mask, v.tags});
    end

    // R9: timeout timing, limits 5 and 0
    for (int j = 0; j < 2; j++) begin
      int lim;
      int k;
      lim = (j == 0) ? 5 : 0;
      tmo_limit_i = 8'(lim);
      send(C_S, 8'h55);
      @(negedge clk_i);
      in_valid_i = 1'b0;
      k = 0;
      while (!grp_valid_o && k < 50) begin
        @(negedge clk_i);
        k++;
      end
      chk(k == lim + 1, "R9 timeout edges", k, lim + 1);
      go_idle(5);
    end

    // R10: stall holds group, fitting input still accepted, blocking input held
    begin
      int base;
      tmo_limit_i = 8'd3;
      grp_ready_i = 1'b0;
      base = log_n;
      send(C_S, 8'hA1);
      send(C_P, 8'hA2);
      send(C_S, 8'hA3);
      @(negedge clk_i);
      in_valid_i = 1'b1; in_cls_i = C_P; in_tag_i = 8'hA4;
      #(CLK_P/4);
      chk(in_ready_o == 1'b0, "R10 upstream blocked", in_ready_o, 0);
      chk(grp_valid_o && grp_slot_vld_o == 6'h01 && tag_of(grp_tag_o, 0) == 8'hA1,
          "R10 held group", {grp_valid_o, grp_slot_vld_o, tag_of(grp_tag_o, 0)}, {1'b1, 6'h01, 8'hA1});
      repeat (3) @(negedge clk_i);
      #(CLK_P/4);
      chk(!in_ready_o && grp_slot_vld_o == 6'h01 && tag_of(grp_tag_o, 0) == 8'hA1,
          "R10 stable under stall", {in_ready_o, grp_slot_vld_o}, {1'b0, 6'h01});
      @(negedge clk_i);
      grp_ready_i = 1'b1;
      #(CLK_P/4);
      chk(in_ready_o == 1'b1, "R10 released", in_ready_o, 1);
      @(posedge clk_i);
      go_idle(20);
      chk(log_n - base == 3, "R10 group count", log_n - base, 3);
      chk(log_mask[base+1] == 6'h07 && tag_of(log_tag[base+1], 1) == 8'hA2 &&
          tag_of(log_tag[base+1], 2) == 8'hA3, "R10 second group",
          log_mask[base+1], 6'h07);
      chk(log_mask[base+2] == 6'h03 && tag_of(log_tag[base+2], 0) == 8'hA4,
          "R10 third group", log_mask[base+2], 6'h03);
    end

    // R12: timeout expiring behind a stalled group
    begin
      tmo_limit_i = 8'd2;
      grp_ready_i = 1'b0;
      send(C_S, 8'hB1);
      send(C_P, 8'hB2);
      go_idle(10);
      chk(grp_valid_o && grp_slot_vld_o == 6'h01, "R12 held before release",
          {grp_valid_o, grp_slot_vld_o}, {1'b1, 6'h01});
      grp_ready_i = 1'b1;
      @(negedge clk_i);
      chk(grp_valid_o && grp_slot_vld_o == 6'h03 && tag_of(grp_tag_o, 1) == 8'hB2,
          "R12 next group back to back", {grp_valid_o, grp_slot_vld_o}, {1'b1, 6'h03});
      @(negedge clk_i);
      chk(grp_valid_o == 1'b0, "R12 drained", grp_valid_o, 0);
    end

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule